// File: doc/BRIEF.md
# Differential 16-Level Amplitude/Phase Soft Demapper

This block turns one received differential symbol of a 16-level amplitude and phase constellation into four signed soft bits. It is fed the quantities that describe the change from the previous symbol: an unsigned amplitude ratio, and the cosine and sine of the phase step, all in fixed point. From these it forms one soft value for the amplitude bit A and one each for the phase bits B, C and D. Each soft value comes with a hard decision and a reliability magnitude, so a following symbol-reliability stage or soft decoder can rank bits against one another on a common scale.

Only comparisons, additions, subtractions, shifts and multiplications by constants are used. The amplitude ratio, whose nominal points are 0.5, 1 and 2, is folded onto the same ±1 scale as the phase bits through a piecewise-linear base-2 logarithm. Bit D is read from the phase vector after a fixed 22.5° counterclockwise rotation. No arctangent and no division appear. Results are registered and appear one clock after the input strobe.

Top module: `dapsk_soft_demapper`

## Requirements
- R1: `out_vld` is high in the cycle after each cycle in which `in_vld` is high, and low after each cycle in which `in_vld` is low.
- R2: While `in_vld` is low, every soft, hard and reliability output keeps its value, whatever the data inputs do.
- R3: Soft values are Q1.7 (128 = 1.0). The ratio is unsigned with 8 fraction bits (256 = 1.0). `soft_a` = 1 − 2·|log2 ratio|, where log2 takes the leading-one position as its integer part and the next 7 bits below it as the fraction, clamped to ±127. So ratio 1.0 gives +127, 0.5, 2.0 and 4.0 give −127, 1.25 gives +64, and 1.5 and 0.75 give 0.
- R4: A ratio of zero gives `soft_a` = −127.
- R5: `soft_c` equals `in_cos` and `soft_b` equals `in_sin`. An input of −128 is output as −127, so no soft output is ever −128.
- R6: `soft_d` = |x′| − |y′|, clamped to ±127. Here x′ = (118·cos − 49·sin) >>> 7 and y′ = (49·cos + 118·sin) >>> 7, each sum being shifted once with rounding toward minus infinity.
- R7: `hard_bits` = {A, B, C, D}, with A at bit 3 and D at bit 0. A bit is 1 exactly when its soft value is negative. A soft value of zero decides 0.
- R8: Each reliability output `rel_x` is the magnitude of its soft value (0 to 127).
- R9: While reset is asserted, and after its release until the first strobe, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input symbol strobe |
| in_ratio | input | 12 | Differential amplitude ratio, unsigned, 8 fraction bits |
| in_cos | input | 8 | Cosine of phase step, signed Q1.7 |
| in_sin | input | 8 | Sine of phase step, signed Q1.7 |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| soft_a | output | 8 | Amplitude soft bit, signed Q1.7 |
| soft_b | output | 8 | Phase soft bit B (sine), signed Q1.7 |
| soft_c | output | 8 | Phase soft bit C (cosine), signed Q1.7 |
| soft_d | output | 8 | Phase soft bit D (rotated vector), signed Q1.7 |
| hard_bits | output | 4 | Hard decisions {A,B,C,D} |
| rel_a | output | 7 | Reliability of A |
| rel_b | output | 7 | Reliability of B |
| rel_c | output | 7 | Reliability of C |
| rel_d | output | 7 | Reliability of D |

## Verification
The only state is the output register and its strobe, so a fault shows at the ports in the cycle after the strobe. A wrong leading-one search or a wrong mantissa slice moves `soft_a` away from its listed value for ratios off a power of two. A wrong rotation constant or a misplaced shift changes `soft_d` by several LSBs. A broken clock enable shows as outputs that move during idle cycles. Directed vectors cover all eight phase sectors, the exact constellation ratios and the points midway between them. Each vector is compared one cycle after it is driven.

// File: rtl/dapsk_pkg.sv
package dapsk_pkg;
  localparam int SOFT_W = 8;
  localparam int MAG_W  = SOFT_W - 1;
  localparam int SOFT_LIM = (1 << MAG_W) - 1;
  localparam int NUM_BITS = 4;

  typedef logic signed [SOFT_W-1:0] soft_t;
  typedef logic [MAG_W-1:0]         mag_t;

  // symmetric saturation to +/- SOFT_LIM
  function automatic soft_t sat_soft(input logic signed [31:0] v);
    if (v > SOFT_LIM)       return soft_t'(SOFT_LIM);
    else if (v < -SOFT_LIM) return soft_t'(-SOFT_LIM);
    else                    return soft_t'(v);
  endfunction
endpackage

// File: rtl/dapsk_amp_soft.sv
module dapsk_amp_soft
  import dapsk_pkg::*;
#(
  parameter int RATIO_W    = 12,
  parameter int RATIO_FRAC = 8
) (
  input  logic [RATIO_W-1:0] ratio,
  output soft_t              soft_amp
);
  localparam int POS_W  = $clog2(RATIO_W);
  localparam int MANT_W = MAG_W;
  localparam int LOG_W  = RATIO_W + MANT_W + 2;
  localparam int ONE    = 1 << MANT_W;

  logic [POS_W-1:0]         lead;
  logic                     found;
  logic [POS_W-1:0]         shamt;
  logic [RATIO_W-1:0]       norm;
  logic [MANT_W-1:0]        mant;
  logic signed [LOG_W-1:0]  lg_int;
  logic signed [LOG_W-1:0]  lg;
  logic signed [LOG_W-1:0]  lg_mag;
  logic signed [LOG_W-1:0]  d3;

  // leading-one search: highest set bit wins
  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int i = 0; i < RATIO_W; i++) begin
      if (ratio[i]) begin
        lead  = POS_W'(i);
        found = 1'b1;
      end
    end
  end

  // piecewise-linear log2 and fold onto the +/-1 scale
  always_comb begin
    shamt  = POS_W'(RATIO_W - 1) - lead;
    norm   = ratio << shamt;
    mant   = norm[RATIO_W-2 -: MANT_W];
    lg_int = LOG_W'($signed({1'b0, lead})) - LOG_W'(RATIO_FRAC);
    lg     = (lg_int <<< MANT_W) + LOG_W'($signed({1'b0, mant}));
    lg_mag = (lg < 0) ? -lg : lg;
    d3     = LOG_W'(ONE) - (lg_mag <<< 1);
    soft_amp = found ? sat_soft(32'(d3)) : soft_t'(-SOFT_LIM);
  end
endmodule

// File: rtl/dapsk_phase_soft.sv
module dapsk_phase_soft
  import dapsk_pkg::*;
#(
  parameter int ROT_COS = 118,
  parameter int ROT_SIN = 49
) (
  input  soft_t cos_v,
  input  soft_t sin_v,
  output soft_t soft_b,
  output soft_t soft_c,
  output soft_t soft_d
);
  localparam int PW = 2 * SOFT_W + 4;

  logic signed [PW-1:0] cx, sx, kc, ks;
  logic signed [PW-1:0] xr, yr, xs, ys, xa, ya, dd;

  always_comb begin
    cx = PW'(cos_v);
    sx = PW'(sin_v);
    kc = PW'(ROT_COS);
    ks = PW'(ROT_SIN);
    // counterclockwise rotation by a fixed angle
    xr = cx * kc - sx * ks;
    yr = cx * ks + sx * kc;
    xs = xr >>> MAG_W;
    ys = yr >>> MAG_W;
    xa = (xs < 0) ? -xs : xs;
    ya = (ys < 0) ? -ys : ys;
    dd = xa - ya;
    soft_d = sat_soft(32'(dd));
    soft_c = sat_soft(32'(cos_v));
    soft_b = sat_soft(32'(sin_v));
  end
endmodule

// File: rtl/dapsk_slicer.sv
module dapsk_slicer
  import dapsk_pkg::*;
(
  input  soft_t soft_in,
  output logic  hard,
  output mag_t  mag
);
  always_comb begin
    hard = soft_in[SOFT_W-1];
    mag  = hard ? mag_t'(-soft_in) : mag_t'(soft_in);
  end
endmodule

// File: rtl/dapsk_soft_demapper.sv
module dapsk_soft_demapper
  import dapsk_pkg::*;
#(
  parameter int RATIO_W    = 12,
  parameter int RATIO_FRAC = 8,
  parameter int ROT_COS    = 118,
  parameter int ROT_SIN    = 49
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [RATIO_W-1:0]       in_ratio,
  input  logic signed [SOFT_W-1:0] in_cos,
  input  logic signed [SOFT_W-1:0] in_sin,
  output logic                     out_vld,
  output logic signed [SOFT_W-1:0] soft_a,
  output logic signed [SOFT_W-1:0] soft_b,
  output logic signed [SOFT_W-1:0] soft_c,
  output logic signed [SOFT_W-1:0] soft_d,
  output logic [NUM_BITS-1:0]      hard_bits,
  output logic [MAG_W-1:0]         rel_a,
  output logic [MAG_W-1:0]         rel_b,
  output logic [MAG_W-1:0]         rel_c,
  output logic [MAG_W-1:0]         rel_d
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // index 3 = A, 2 = B, 1 = C, 0 = D
  soft_t raw [NUM_BITS];
  logic [NUM_BITS-1:0] hard_raw;
  mag_t  mag_raw [NUM_BITS];

  dapsk_amp_soft #(.RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC)) u_amp (
    .ratio    (in_ratio),
    .soft_amp (raw[3])
  );

  dapsk_phase_soft #(.ROT_COS(ROT_COS), .ROT_SIN(ROT_SIN)) u_phase (
    .cos_v  (in_cos),
    .sin_v  (in_sin),
    .soft_b (raw[2]),
    .soft_c (raw[1]),
    .soft_d (raw[0])
  );

  for (genvar g = 0; g < NUM_BITS; g++) begin : g_slice
    dapsk_slicer u_slice (
      .soft_in (raw[g]),
      .hard    (hard_raw[g]),
      .mag     (mag_raw[g])
    );
  end

  // output register with explicit clock enable
  soft_t soft_q [NUM_BITS];
  soft_t soft_n [NUM_BITS];
  mag_t  mag_q  [NUM_BITS];
  mag_t  mag_n  [NUM_BITS];
  logic [NUM_BITS-1:0] hard_q, hard_n;
  logic vld_q, vld_n;

  always_comb begin
    vld_n = in_vld;
    for (int k = 0; k < NUM_BITS; k++) begin
      soft_n[k] = in_vld ? raw[k]     : soft_q[k];
      mag_n[k]  = in_vld ? mag_raw[k] : mag_q[k];
    end
    hard_n = in_vld ? hard_raw : hard_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      hard_q <= '0;
      for (int k = 0; k < NUM_BITS; k++) begin
        soft_q[k] <= '0;
        mag_q[k]  <= '0;
      end
    end else begin
      vld_q  <= vld_n;
      hard_q <= hard_n;
      for (int k = 0; k < NUM_BITS; k++) begin
        soft_q[k] <= soft_n[k];
        mag_q[k]  <= mag_n[k];
      end
    end
  end

  assign out_vld   = vld_q;
  assign soft_a    = soft_q[3];
  assign soft_b    = soft_q[2];
  assign soft_c    = soft_q[1];
  assign soft_d    = soft_q[0];
  assign hard_bits = hard_q;
  assign rel_a     = mag_q[3];
  assign rel_b     = mag_q[2];
  assign rel_c     = mag_q[1];
  assign rel_d     = mag_q[0];

  // ---------------- assertions ----------------
  assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_vld |=> out_vld);
  assert_vld_idle_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_vld |=> !out_vld);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_vld |=> ($stable(soft_a) && $stable(soft_b) && $stable(soft_c) &&
                 $stable(soft_d) && $stable(hard_bits)));
  assert_no_min_code_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (soft_a != soft_t'(-SOFT_LIM - 1)) && (soft_b != soft_t'(-SOFT_LIM - 1)) &&
    (soft_c != soft_t'(-SOFT_LIM - 1)) && (soft_d != soft_t'(-SOFT_LIM - 1)));
  assert_hard_sign_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    hard_bits == {soft_a < 0, soft_b < 0, soft_c < 0, soft_d < 0});
  assert_rel_mag_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (32'(rel_a) == ((soft_a < 0) ? -32'(soft_a) : 32'(soft_a))) &&
    (32'(rel_d) == ((soft_d < 0) ? -32'(soft_d) : 32'(soft_d))));
endmodule

// File: tb/test_dapsk_soft_demapper.sv
module test_dapsk_soft_demapper;
  logic clk = 1'b0;
  logic rst_n;
  logic in_vld;
  logic [11:0] in_ratio;
  logic signed [7:0] in_cos, in_sin;
  logic out_vld;
  logic signed [7:0] soft_a, soft_b, soft_c, soft_d;
  logic [3:0] hard_bits;
  logic [6:0] rel_a, rel_b, rel_c, rel_d;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int    a, b, c, d;
    string tag_a;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  dapsk_soft_demapper i_dapsk_soft_demapper (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ratio(in_ratio),
    .in_cos(in_cos), .in_sin(in_sin), .out_vld(out_vld),
    .soft_a(soft_a), .soft_b(soft_b), .soft_c(soft_c), .soft_d(soft_d),
    .hard_bits(hard_bits), .rel_a(rel_a), .rel_b(rel_b), .rel_c(rel_c),
    .rel_d(rel_d)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int d_model(input int x, input int y);
    int xp, yp;
    xp = (x * 118 - y * 49) >>> 7;
    yp = (x * 49 + y * 118) >>> 7;
    return sat(iabs(xp) - iabs(yp));
  endfunction

  task automatic drive(input int ratio, input int c, input int s, input int exp_a,
                       input string tag);
    exp_t e;
    @(negedge clk);
    in_vld   = 1'b1;
    in_ratio = 12'(ratio);
    in_cos   = 8'(c);
    in_sin   = 8'(s);
    e.a = exp_a;
    e.b = sat(s);
    e.c = sat(c);
    e.d = d_model(c, s);
    e.tag_a = tag;
    sb.push_back(e);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_vld) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1 unexpected out_vld", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(soft_a) == e.a, e.tag_a, int'(soft_a), e.a);
          check(int'(soft_b) == e.b, "R5 soft_b", int'(soft_b), e.b);
          check(int'(soft_c) == e.c, "R5 soft_c", int'(soft_c), e.c);
          check(int'(soft_d) == e.d, "R6 soft_d", int'(soft_d), e.d);
          check(int'(hard_bits) == {28'd0, e.a < 0, e.b < 0, e.c < 0, e.d < 0},
                "R7 hard_bits", int'(hard_bits),
                int'({e.a < 0, e.b < 0, e.c < 0, e.d < 0}));
          check(int'(rel_a) == iabs(e.a) && int'(rel_b) == iabs(e.b) &&
                int'(rel_c) == iabs(e.c) && int'(rel_d) == iabs(e.d),
                "R8 reliability a", int'(rel_a), iabs(e.a));
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 20);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic signed [7:0] sa, sb_, sc, sd;
    logic [3:0] hb;
    rst_n = 1'b0; in_vld = 1'b0; in_ratio = '0; in_cos = '0; in_sin = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_vld == 1'b0, "R9 out_vld in reset", int'(out_vld), 0);
    check(soft_a == 0 && soft_d == 0 && hard_bits == 0 && rel_a == 0,
          "R9 outputs in reset", int'(soft_a), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0 && soft_b == 0, "R9 idle after release", int'(out_vld), 0);

    // constellation points and midpoints
    drive(256, 127, 0, 127, "R3 ratio 1.0");
    drive(128, 90, 90, -127, "R3 ratio 0.5");
    drive(512, 0, 127, -127, "R3 ratio 2.0");
    drive(320, -90, 90, 64, "R3 ratio 1.25");
    drive(384, -127, 0, 0, "R3 ratio 1.5");
    drive(192, -90, -90, 0, "R3 ratio 0.75");
    drive(0, 0, -128, -127, "R4 ratio zero");
    drive(4095, 90, -90, -127, "R3 ratio max");
    drive(1024, 64, -64, -127, "R3 ratio 4.0");
    drive(1, -128, -128, -127, "R3 ratio tiny");
    drive(256, 30, 12, 127, "R3 ratio 1.0 small vector");

    // R2 hold: idle cycles with changing data
    @(negedge clk);
    in_vld = 1'b0; in_ratio = 12'd384; in_cos = -8'sd5; in_sin = 8'sd77;
    @(negedge clk);
    sa = soft_a; sb_ = soft_b; sc = soft_c; sd = soft_d; hb = hard_bits;
    in_ratio = 12'd128; in_cos = 8'sd100; in_sin = -8'sd100;
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R1 out_vld low when idle", int'(out_vld), 0);
    check(soft_a == sa && soft_b == sb_ && soft_c == sc && soft_d == sd && hard_bits == hb,
          "R2 outputs held", int'(soft_d), int'(sd));

    // isolated strobe after gap
    drive(256, -127, 0, 127, "R3 ratio 1.0 after gap");
    @(negedge clk);
    in_vld = 1'b0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R1 all results delivered", sb.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule